// File: doc/BRIEF.md
# Multiple-register transfer sequencer

This block moves a selected subset of a sixteen-entry register file (eight data registers D0..D7 at indices 0..7 and eight address registers A0..A7 at indices 8..15) to or from consecutive memory locations. A start pulse supplies the selection mask, the operand size, the addressing mode, the direction, the base address and the index of the address register that holds the base. The block then walks the selected registers one at a time. For each one it issues a memory transfer over a valid/ready handshake and reads or writes the register file.

Three addressing modes are supported. Control mode walks upward and leaves the addressing register untouched. Predecrement mode stores registers downward and writes the final address back. Postincrement mode loads registers upward and writes the advanced address back. Combinations that the mode does not permit, and an empty mask, finish at once without touching memory or registers.

Top module: `mm_seq`

## Requirements
- R1: A register takes part only when its mask bit is set. Every set bit causes exactly one memory access and every clear bit causes none. In predecrement mode (mode 1), mask bit j selects register index 15-j. In modes 0 and 2, mask bit j selects register index j.
- R2: In control mode (mode 0) and postincrement mode (mode 2), registers are visited in ascending index order. The first access uses the base address, and each later access adds the operand length: 2 for word (size_long_i=0) and 4 for long.
- R3: Predecrement mode visits register indices in descending order. The first access goes to base minus the operand length, and each later access subtracts the operand length again.
- R4: A long store writes the full 32-bit register. A word store writes the register's low 16 bits with the upper 16 bits zero.
- R5: A long load writes the full fetched word into the register. A word load writes the low 16 fetched bits, sign-extended to 32 bits, into either a data or an address register.
- R6: After a predecrement store, the addressing register (index 8+an) is written with the address of the last operand stored. If that register is itself in the list, the value stored for it is the base minus the operand length.
- R7: After a postincrement load, the addressing register is written with the last load address plus the operand length. If that register is itself in the list, its final value is its fetched (extended) value plus the operand length.
- R8: Control mode never writes the addressing register back, and a control-mode store writes no register at all.
- R9: A memory request holds its address, direction and data until ready is seen, and only one transfer is outstanding at a time.
- R10: Predecrement with load direction, postincrement with store direction, or mode value 3 raises done and err in the cycle after start. No memory access and no register write takes place.
- R11: An all-zero mask raises done in the cycle after start, with err low, no memory access and no register write.
- R12: done is a single-cycle pulse that follows the last transfer, or the writeback when there is one. done and err are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| mask_i | input | 16 | Register selection mask |
| size_long_i | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| mode_i | input | 2 | 0 control, 1 predecrement, 2 postincrement, 3 illegal |
| to_mem_i | input | 1 | 1 = registers to memory, 0 = memory to registers |
| base_addr_i | input | 32 | Starting address (value of the addressing register) |
| addr_reg_i | input | 3 | Index of the addressing address register |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory accepts or completes the request |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| done_o | output | 1 | Operation complete pulse |
| err_o | output | 1 | Illegal mode/direction, valid with done |

## Verification
A corrupted pending mask or a wrong position decode shows up as a missing, extra or misordered memory access, and the scoreboard reports it at the first handshake that differs from the expected stream. A wrong address step shows on the second access address. A wrong writeback value shows on the single register write that precedes done, and a stuck state shows as a missing done pulse. Memory ready is stalled at irregular intervals, so a request that drifts while waiting is caught on the cycle after the stall.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    MODE_CTRL = 2'd0,
    MODE_PRE  = 2'd1,
    MODE_POST = 2'd2
  } mm_mode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_XFER,
    S_WB,
    S_FIN
  } mm_state_e;
endpackage

// File: rtl/mm_first_set.sv
module mm_first_set #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          last_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  // at most one bit left
  assign last_o = (vec_i & (vec_i - N'(1))) == '0;
endmodule

// File: rtl/mm_addr_step.sv
module mm_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic          long_i,
  input  logic          down_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] len;
  assign len    = long_i ? AW'(4) : AW'(2);
  assign addr_o = down_i ? addr_i - len : addr_i + len;
endmodule

// File: rtl/mm_seq.sv
module mm_seq
  import mm_pkg::*;
#(
  parameter int N_REGS = 16,
  parameter int XLEN   = 32,
  localparam int IW    = $clog2(N_REGS),
  localparam int AIW   = IW - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [N_REGS-1:0] mask_i,
  input  logic            size_long_i,
  input  logic [1:0]      mode_i,
  input  logic            to_mem_i,
  input  logic [XLEN-1:0] base_addr_i,
  input  logic [AIW-1:0]  addr_reg_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            mem_ready_i,
  output logic [IW-1:0]   rf_raddr_o,
  input  logic [XLEN-1:0] rf_rdata_i,
  output logic            rf_we_o,
  output logic [IW-1:0]   rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            done_o,
  output logic            err_o
);
  mm_state_e        state_q;
  mm_mode_e         mode_q;
  logic             long_q, to_mem_q, self_q, err_q;
  logic [AIW-1:0]   an_q;
  logic [N_REGS-1:0] pend_q;
  logic [XLEN-1:0]  addr_q, first_q, last_q, self_val_q;

  logic [IW-1:0]    pos, cur_reg, an_reg;
  logic             is_last, hs, illegal, is_pre;
  logic [XLEN-1:0]  base_dec, addr_next, self_plus, ext_rdata, st_src;

  mm_first_set #(.N(N_REGS)) u_first (
    .vec_i (pend_q),
    .idx_o (pos),
    .last_o(is_last)
  );

  mm_addr_step #(.AW(XLEN)) u_base_dec (
    .addr_i(base_addr_i), .long_i(size_long_i), .down_i(1'b1), .addr_o(base_dec)
  );
  mm_addr_step #(.AW(XLEN)) u_step (
    .addr_i(addr_q), .long_i(long_q), .down_i(is_pre), .addr_o(addr_next)
  );
  mm_addr_step #(.AW(XLEN)) u_self (
    .addr_i(self_val_q), .long_i(long_q), .down_i(1'b0), .addr_o(self_plus)
  );

  assign is_pre  = mode_q == MODE_PRE;
  assign cur_reg = is_pre ? IW'(N_REGS - 1) - pos : pos;
  assign an_reg  = {1'b1, an_q};
  assign hs      = (state_q == S_XFER) && mem_ready_i;
  assign illegal = (mode_i == 2'd3) ||
                   (mode_i == MODE_PRE && !to_mem_i) ||
                   (mode_i == MODE_POST && to_mem_i);

  assign ext_rdata = long_q ? mem_rdata_i
                            : {{(XLEN-16){mem_rdata_i[15]}}, mem_rdata_i[15:0]};
  // predecrement self-store sends the once-decremented address
  assign st_src    = (is_pre && cur_reg == an_reg) ? first_q : rf_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      mode_q     <= MODE_CTRL;
      long_q     <= 1'b0;
      to_mem_q   <= 1'b0;
      self_q     <= 1'b0;
      err_q      <= 1'b0;
      an_q       <= '0;
      pend_q     <= '0;
      addr_q     <= '0;
      first_q    <= '0;
      last_q     <= '0;
      self_val_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          mode_q   <= mm_mode_e'(mode_i);
          long_q   <= size_long_i;
          to_mem_q <= to_mem_i;
          an_q     <= addr_reg_i;
          pend_q   <= mask_i;
          self_q   <= 1'b0;
          first_q  <= base_dec;
          addr_q   <= (mode_i == MODE_PRE) ? base_dec : base_addr_i;
          err_q    <= illegal;
          state_q  <= (illegal || mask_i == '0) ? S_FIN : S_XFER;
        end
        S_XFER: if (mem_ready_i) begin
          pend_q[pos] <= 1'b0;
          addr_q      <= addr_next;
          last_q      <= addr_q;
          if (mode_q == MODE_POST && cur_reg == an_reg) begin
            self_q     <= 1'b1;
            self_val_q <= ext_rdata;
          end
          if (is_last) state_q <= (mode_q == MODE_CTRL) ? S_FIN : S_WB;
        end
        S_WB:    state_q <= S_FIN;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o   = state_q == S_XFER;
  assign mem_we_o    = to_mem_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = long_q ? st_src : {{(XLEN-16){1'b0}}, st_src[15:0]};
  assign rf_raddr_o  = cur_reg;
  assign rf_we_o     = (hs && !to_mem_q) || state_q == S_WB;
  assign rf_waddr_o  = (state_q == S_WB) ? an_reg : cur_reg;
  assign rf_wdata_o  = (state_q != S_WB) ? ext_rdata :
                       is_pre            ? last_q :
                       self_q            ? self_plus : addr_q;
  assign done_o      = state_q == S_FIN;
  assign err_o       = done_o && err_q;

  // R9
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  err_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_req_o && !$past(mem_req_o));

  // R1
  one_bit_per_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |=> $countones(pend_q) == $countones($past(pend_q)) - 1);

  // R3
  pre_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && is_pre && !is_last |=>
      XLEN'($past(mem_addr_o) - mem_addr_o) == (long_q ? XLEN'(4) : XLEN'(2)));
endmodule

// File: tb/mm_seq_test.sv
module mm_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic        size_long_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        to_mem_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic [2:0]  addr_reg_i = '0;
  logic        mem_req_o, mem_we_o, mem_ready_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [3:0]  rf_raddr_o, rf_waddr_o;
  logic [31:0] rf_rdata_i, rf_wdata_o;
  logic        rf_we_o, done_o, err_o;

  logic [31:0] rf_m [16];
  logic [64:0] mem_q [$];
  logic [35:0] rf_q [$];
  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  logic [7:0] lfsr = 8'h5B;
  int stall_cnt = 0;
  bit prev_stall = 0;
  logic [31:0] prev_addr = '0;

  always #10 clk_i = ~clk_i;

  mm_seq uut (
    .clk_i, .rst_ni, .start_i, .mask_i, .size_long_i, .mode_i, .to_mem_i,
    .base_addr_i, .addr_reg_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .mem_ready_i, .rf_raddr_o, .rf_rdata_i, .rf_we_o, .rf_waddr_o,
    .rf_wdata_o, .done_o, .err_o
  );

  function automatic logic [31:0] mem_val(logic [31:0] a);
    return {~a[15:0], a[15:0] ^ 16'h9C31};
  endfunction

  assign mem_rdata_i = mem_val(mem_addr_o);
  assign rf_rdata_i  = rf_m[rf_raddr_o];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++)
        rf_m[i] <= {4'(i), 4'hC, 8'(i * 17), 8'(8'h8F ^ 8'(i * 19)), 8'(8'h5A + i)};
    end else if (rf_we_o) begin
      rf_m[rf_waddr_o] <= rf_wdata_o;
    end
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as the design produces transfers and writes
  always @(negedge clk_i) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (!rst_ni) mem_ready_i = 1'b0;
    else mem_ready_i = mem_req_o && (lfsr[0] || stall_cnt >= 2);
    #2;
    if (rst_ni) begin
      if (prev_stall)  // R9
        check(mem_req_o && mem_addr_o == prev_addr, "R9", {31'd0, mem_req_o, mem_addr_o},
              {32'd1, prev_addr});
      if (mem_req_o && mem_ready_i) begin
        if (mem_q.size() == 0) begin
          check(0, {cur_req, " unexpected access"}, {mem_we_o, mem_addr_o}, 0);
        end else begin
          logic [64:0] e;
          e = mem_q.pop_front();
          check(mem_we_o == e[64] && mem_addr_o == e[63:32] &&
                (!e[64] || mem_wdata_o == e[31:0]),
                cur_req, {mem_addr_o, e[64] ? mem_wdata_o : 32'd0}, e[63:0]);
        end
      end
      prev_stall = mem_req_o && !mem_ready_i;
      prev_addr  = mem_addr_o;
      stall_cnt  = prev_stall ? stall_cnt + 1 : 0;
      if (rf_we_o) begin
        if (rf_q.size() == 0) begin
          check(0, {cur_req, " unexpected register write"}, {rf_waddr_o, rf_wdata_o}, 0);
        end else begin
          logic [35:0] r;
          r = rf_q.pop_front();
          check(rf_waddr_o == r[35:32] && rf_wdata_o == r[31:0], cur_req,
                {28'd0, rf_waddr_o, rf_wdata_o}, {28'd0, r});
        end
      end
    end
  end

  // driver: builds the expected stream from the requirements, then runs the operation
  task automatic run_op(string req, logic [15:0] mask, bit lng, logic [1:0] mode,
                        bit to_mem, logic [2:0] an);
    logic [31:0] len, a, base, d, v, sv, last;
    bit ill, self;
    int cyc;
    cur_req = req;
    base = rf_m[8 + an];
    len  = lng ? 32'd4 : 32'd2;
    ill  = (mode == 2'd3) || (mode == 2'd1 && !to_mem) || (mode == 2'd2 && to_mem);
    self = 0; sv = '0; last = '0;
    if (!ill && mask != 0) begin
      if (mode == 2'd1) begin
        a = base - len;
        for (int j = 0; j < 16; j++) if (mask[j]) begin
          d = (15 - j == 8 + an) ? base - len : rf_m[15 - j];
          mem_q.push_back({1'b1, a, lng ? d : {16'd0, d[15:0]}});
          last = a;
          a = a - len;
        end
        rf_q.push_back({4'(8 + an), last});
      end else begin
        a = base;
        for (int j = 0; j < 16; j++) if (mask[j]) begin
          if (to_mem) begin
            d = rf_m[j];
            mem_q.push_back({1'b1, a, lng ? d : {16'd0, d[15:0]}});
          end else begin
            d = mem_val(a);
            v = lng ? d : {{16{d[15]}}, d[15:0]};
            mem_q.push_back({1'b0, a, 32'd0});
            rf_q.push_back({4'(j), v});
            if (mode == 2'd2 && j == 8 + an) begin self = 1; sv = v + len; end
          end
          a = a + len;
        end
        if (mode == 2'd2) rf_q.push_back({4'(8 + an), self ? sv : a});
      end
    end
    @(negedge clk_i);
    mask_i = mask; size_long_i = lng; mode_i = mode; to_mem_i = to_mem;
    base_addr_i = base; addr_reg_i = an; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 400) begin
      @(negedge clk_i);
      cyc++;
    end
    if (ill || mask == 0)  // R10 R11: done in the cycle after start
      check(cyc == 0, ill ? "R10" : "R11", 64'(cyc), 0);
    check(done_o && err_o == ill, ill ? "R10" : req, {done_o, err_o}, {1'b1, ill});
    @(negedge clk_i);
    check(!done_o, "R12", 64'(done_o), 0);
    check(mem_q.size() == 0 && rf_q.size() == 0, "R1", 64'(mem_q.size() + rf_q.size()), 0);
    mem_q.delete();
    rf_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check(!done_o && !err_o && !mem_req_o && !rf_we_o, "R12",
          {done_o, err_o, mem_req_o, rf_we_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    run_op("R2", 16'h8105, 1'b1, 2'd0, 1'b1, 3'd2);  // R4 R8 control long store
    run_op("R5", 16'h00F0, 1'b0, 2'd0, 1'b0, 3'd0);  // R8 control word load, no writeback
    run_op("R2", 16'hC00F, 1'b0, 2'd0, 1'b1, 3'd5);  // R4 word store low halves
    run_op("R6", 16'h0103, 1'b1, 2'd1, 1'b1, 3'd6);  // R3 predec long, self in list
    run_op("R3", 16'hF000, 1'b0, 2'd1, 1'b1, 3'd2);  // R6 predec word, no self
    run_op("R7", 16'h0801, 1'b1, 2'd2, 1'b0, 3'd3);  // postinc long, self in list
    run_op("R5", 16'h60C0, 1'b0, 2'd2, 1'b0, 3'd1);  // R7 postinc word, A-reg sign-extended
    run_op("R1", 16'hFFFF, 1'b1, 2'd2, 1'b0, 3'd7);  // full mask
    run_op("R10", 16'h0011, 1'b1, 2'd1, 1'b0, 3'd0);
    run_op("R10", 16'h0011, 1'b1, 2'd2, 1'b1, 3'd0);
    run_op("R10", 16'h0011, 1'b0, 2'd3, 1'b1, 3'd0);
    run_op("R11", 16'h0000, 1'b1, 2'd1, 1'b1, 3'd4);
    run_op("R11", 16'h0000, 1'b0, 2'd0, 1'b0, 3'd4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule